// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a simple synchronous host port and an external asynchronous static RAM. The RAM has a 19-bit address, an 8-bit shared data bus and three active-low controls: chip select, output enable and write strobe. The host places one byte-wide read or write request while the controller is idle. The controller turns that request into a strobe sequence and answers with a one-cycle acknowledge. For a read, the acknowledge comes with the captured byte.

All RAM timing minimums are met by counting system clock cycles. Each phase count is computed at elaboration time from a nanosecond limit and the clock period. The limit is divided by the period, rounded up, and never allowed to fall below one cycle. Writes are timed by the write strobe alone, with output enable held high throughout. Before the controller's own data drivers switch on, a bus turnaround phase lets the RAM release the shared pins. The drivers switch off on the same edge that ends the write.

The data pins appear as a separate input, output and output-enable triple. The pad ring or a wrapper resolves them into one bidirectional bus.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, chip select, output enable and write strobe are all high (inactive), the data drivers are off, the acknowledge is low and the ready flag is high.
- R2: Between transactions all three strobes are high and the drivers are off. A request is accepted only while ready is high, and ready is low for the whole of a transaction. A request raised while busy produces no access and no acknowledge.
- R3: A read holds chip select and output enable low together for exactly RD_CYC cycles, with the write strobe high. RD_CYC is ceil(read access time / clock period), with a minimum of 1.
- R4: On the edge that ends a read, the byte on the RAM data input is captured. In the following cycle the acknowledge is high for exactly one cycle and the read-data output holds that byte.
- R5: A write first holds chip select low for exactly TURN_CYC cycles with output enable and write strobe high and the drivers off. TURN_CYC is ceil(turnaround time / period), with a minimum of 1. Output enable stays high for the whole write.
- R6: The write strobe is then low for exactly WR_CYC cycles, where WR_CYC is the larger of the rounded-up pulse-width and data-setup counts. The drivers are on exactly while the write strobe is low, and they present the request's data byte.
- R7: The write strobe, chip select and the drivers are all released on one clock edge. The one-cycle acknowledge follows in the next cycle.
- R8: The RAM address output equals the request address and stays unchanged for as long as chip select is low.
- R9: A new request may be presented in the acknowledge cycle and is accepted there. A write that directly follows a read still gets its full turnaround phase.
- R10: Output enable and the drivers are never active in the same cycle, and the write strobe is never low while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| req_valid | input | 1 | Host request strobe, taken only while req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Byte to be written |
| req_ready | output | 1 | High while idle and able to take a request |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Byte captured by the last read |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_addr | output | ADDR_W | RAM address |
| mem_dq_out | output | DATA_W | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Tri-state enable for the data pins, active high |
| mem_dq_in | input | DATA_W | Data received from the RAM pins |

## Verification
The bench builds the block with a 5 ns clock and limits of 10 ns read access, 8 ns write pulse, 6 ns data setup and 4 ns turnaround. These give RD_CYC = 2, WR_CYC = 2 and TURN_CYC = 1. With these values the pulse and setup counts both round up from a fraction, and they tie in the maximum. Each phase is also short enough that back-to-back transactions, a request injected mid-write and write-after-read turnaround all fit into a few cycles. A behavioural byte array in the bench answers reads and stores writes, so every written byte is confirmed by reading it back through the ports.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_TURN  = 2'd2,
    ST_WRITE = 2'd3
  } seq_state_e;

  // Round a time limit up to whole clock cycles, never below one cycle.
  function automatic int ps_to_cycles(input int limit_ps, input int clk_ps);
    int n;
    n = (limit_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load | ~expired;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int RD_CYC   = 2,
  parameter int WR_CYC   = 2,
  parameter int TURN_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             phase_done,
  output logic             phase_load,
  output logic [CNT_W-1:0] phase_len,
  output logic             accept,
  output logic             capture,
  output logic             ready,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe,
  output logic             ack
);

  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LD   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

  seq_state_e state_q, state_d;
  logic ce_q, ce_d;
  logic oe_q, oe_d;
  logic we_q, we_d;
  logic drv_q, drv_d;
  logic ack_q, ack_d;

  always_comb begin
    state_d    = state_q;
    ce_d       = ce_q;
    oe_d       = oe_q;
    we_d       = we_q;
    drv_d      = drv_q;
    ack_d      = 1'b0;
    phase_load = 1'b0;
    phase_len  = '0;
    accept     = 1'b0;
    capture    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept     = 1'b1;
          phase_load = 1'b1;
          ce_d       = 1'b0;
          if (req_write) begin
            phase_len = TURN_LD;
            state_d   = ST_TURN;
          end else begin
            phase_len = RD_LD;
            oe_d      = 1'b0;
            state_d   = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (phase_done) begin
          capture = 1'b1;
          ack_d   = 1'b1;
          ce_d    = 1'b1;
          oe_d    = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_TURN: begin
        if (phase_done) begin
          phase_load = 1'b1;
          phase_len  = WR_LD;
          we_d       = 1'b0;
          drv_d      = 1'b1;
          state_d    = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (phase_done) begin
          we_d    = 1'b1;
          drv_d   = 1'b0;
          ce_d    = 1'b1;
          ack_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_q    <= 1'b1;
      oe_q    <= 1'b1;
      we_q    <= 1'b1;
      drv_q   <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_q    <= ce_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      drv_q   <= drv_d;
      ack_q   <= ack_d;
    end
  end

  assign ready = (state_q == ST_IDLE);
  assign ce_n  = ce_q;
  assign oe_n  = oe_q;
  assign we_n  = we_q;
  assign dq_oe = drv_q;
  assign ack   = ack_q;

endmodule

// File: rtl/sram_bus_regs.sv
module sram_bus_regs #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= dq_in;
  end

  assign addr  = addr_q;
  assign wdata = wdata_q;
  assign rdata = rdata_q;

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int CLK_PS    = 5000,
  parameter int T_RD_PS   = 10000,
  parameter int T_WEP_PS  = 8000,
  parameter int T_DS_PS   = 6000,
  parameter int T_TURN_PS = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC   = ps_to_cycles(T_RD_PS, CLK_PS);
  localparam int WR_CYC   = max_int(ps_to_cycles(T_WEP_PS, CLK_PS),
                                    ps_to_cycles(T_DS_PS, CLK_PS));
  localparam int TURN_CYC = ps_to_cycles(T_TURN_PS, CLK_PS);
  localparam int MAX_CYC  = max_int(max_int(RD_CYC, WR_CYC), TURN_CYC);
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic             phase_load;
  logic [CNT_W-1:0] phase_len;
  logic             phase_done;
  logic             accept;
  logic             capture;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (phase_load),
    .load_val (phase_len),
    .expired  (phase_done)
  );

  sram_seq_fsm #(
    .CNT_W    (CNT_W),
    .RD_CYC   (RD_CYC),
    .WR_CYC   (WR_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .phase_done (phase_done),
    .phase_load (phase_load),
    .phase_len  (phase_len),
    .accept     (accept),
    .capture    (capture),
    .ready      (req_ready),
    .ce_n       (mem_ce_n),
    .oe_n       (mem_oe_n),
    .we_n       (mem_we_n),
    .dq_oe      (mem_dq_oe),
    .ack        (ack)
  );

  sram_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (mem_dq_in),
    .addr      (mem_addr),
    .wdata     (mem_dq_out),
    .rdata     (rd_data)
  );

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int ADDR_W   = 19,
  parameter int RD_CYC   = 2,
  parameter int WR_CYC   = 2,
  parameter int TURN_CYC = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              ack,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);

  logic [7:0] oe_run, we_run, turn_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_run   <= '0;
      we_run   <= '0;
      turn_run <= '0;
    end else begin
      oe_run   <= (!mem_ce_n && !mem_oe_n) ? oe_run + 8'd1 : 8'd0;
      we_run   <= (!mem_we_n) ? we_run + 8'd1 : 8'd0;
      turn_run <= (!mem_ce_n && mem_oe_n && mem_we_n) ? turn_run + 8'd1 : 8'd0;
    end
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  // R3
  read_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_run == 8'(RD_CYC)));

  // R4
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R5
  turn_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (turn_run == 8'(TURN_CYC)));

  // R6
  we_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == 8'(WR_CYC)));

  // R6
  drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && !mem_ce_n));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_ce_n && !mem_dq_oe));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  // R10
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && mem_we_n));

endmodule

bind sram_seq_ctrl sram_seq_chk #(
  .ADDR_W   (ADDR_W),
  .RD_CYC   (RD_CYC),
  .WR_CYC   (WR_CYC),
  .TURN_CYC (TURN_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .ack       (ack),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr)
);

// File: tb/tb_sram_seq_ctrl.sv
module tb_sram_seq_ctrl;

  localparam int CLK_PS = 5000;
  // Expected phase lengths from the requirements (10/8/6/4 ns on a 5 ns clock).
  localparam int E_RD   = (10000 + CLK_PS - 1) / CLK_PS;
  localparam int E_WEP  = (8000 + CLK_PS - 1) / CLK_PS;
  localparam int E_DS   = (6000 + CLK_PS - 1) / CLK_PS;
  localparam int E_WR   = (E_WEP > E_DS) ? E_WEP : E_DS;
  localparam int E_TURN = (4000 + CLK_PS - 1) / CLK_PS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, ack;
  logic [7:0]  rd_data;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [18:0] mem_addr;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2500 clk = ~clk;

  sram_seq_ctrl #(
    .CLK_PS(CLK_PS), .T_RD_PS(10000), .T_WEP_PS(8000),
    .T_DS_PS(6000), .T_TURN_PS(4000)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .ack(ack), .rd_data(rd_data), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Behavioural RAM: 1024 bytes indexed by the low address bits.
  logic [7:0] ram [1024];

  function automatic logic [7:0] preset(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) ram[i] <= preset(i);
    end else if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
      ram[mem_addr[9:0]] <= mem_dq_out;
    end
  end

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? ram[mem_addr[9:0]] : 8'h00;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Runs one transaction starting at a negedge; returns at the ack negedge.
  task automatic run_txn(input logic wr, input logic [18:0] a, input logic [7:0] d,
                         input bit inject, output logic [7:0] rdat,
                         output int n_oe, output int n_we, output int n_turn,
                         output int viol);
    int cyc;
    n_oe = 0; n_we = 0; n_turn = 0; viol = 0; cyc = 0;
    chk("R9", "ready at request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!ack && cyc < 40) begin
      cyc++;
      if (req_ready) viol++;
      if (!mem_ce_n && !mem_oe_n) n_oe++;
      if (!mem_we_n) n_we++;
      if (!mem_ce_n && mem_oe_n && mem_we_n) n_turn++;
      if (!mem_oe_n && (mem_dq_oe || !mem_we_n)) viol++;
      if (mem_dq_oe !== !mem_we_n) viol++;
      if (mem_dq_oe && mem_dq_out !== d) viol++;
      if (!mem_ce_n && mem_addr !== a) viol++;
      if (mem_ce_n) viol++;
      if (inject && cyc == 1) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h002AA; req_wdata = 8'h77;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk("R7", "ack reached", 32'(ack), 32'd1);
    chk("R7", "strobes released at ack",
        {28'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 32'hE);
    rdat = rd_data;
  endtask

  task automatic t_reset;
    chk("R1", "strobes in reset", {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 32'h7);
    chk("R1", "drivers in reset", 32'(mem_dq_oe), 32'd0);
    chk("R1", "ack in reset", 32'(ack), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "state after reset",
        {27'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 32'h1D);
  endtask

  task automatic t_read(input logic [18:0] a, input logic [7:0] exp);
    logic [7:0] r; int o, w, t, v;
    run_txn(1'b0, a, 8'h00, 1'b0, r, o, w, t, v);
    chk("R3", "read strobe cycles", 32'(o), 32'(E_RD));
    chk("R3", "no write strobe on read", 32'(w), 32'd0);
    chk("R8", "read bus rules", 32'(v), 32'd0);
    chk("R4", "read data", 32'(r), 32'(exp));
    @(negedge clk);
    chk("R4", "ack one cycle", 32'(ack), 32'd0);
  endtask

  task automatic t_write(input logic [18:0] a, input logic [7:0] d, input bit inject);
    logic [7:0] r; int o, w, t, v;
    run_txn(1'b1, a, d, inject, r, o, w, t, v);
    chk("R5", "turnaround cycles", 32'(t), 32'(E_TURN));
    chk("R5", "oe held high in write", 32'(o), 32'd0);
    chk("R6", "write strobe cycles", 32'(w), 32'(E_WR));
    chk("R10", "write bus rules", 32'(v), 32'd0);
  endtask

  task automatic t_busy_ignored;
    t_write(19'h00155, 8'h0F, 1'b1);
    @(negedge clk);
    chk("R2", "no second ack", 32'(ack), 32'd0);
    chk("R2", "idle after txn", {30'd0, req_ready, mem_ce_n}, 32'h3);
    t_read(19'h002AA, preset(10'h2AA));
    t_read(19'h00155, 8'h0F);
  endtask

  task automatic t_back_to_back;
    logic [7:0] r; int o, w, t, v;
    run_txn(1'b1, 19'h00000, 8'hFF, 1'b0, r, o, w, t, v);
    run_txn(1'b0, 19'h00000, 8'h00, 1'b0, r, o, w, t, v);
    chk("R9", "b2b read data", 32'(r), 32'hFF);
    run_txn(1'b1, 19'h00300, 8'h00, 1'b0, r, o, w, t, v);
    chk("R9", "turnaround after read", 32'(t), 32'(E_TURN));
    chk("R9", "b2b write bus rules", 32'(v), 32'd0);
    @(negedge clk);
    t_read(19'h00300, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    t_read(19'h00012, preset(10'h012));
    @(negedge clk);
    t_write(19'h7FFFF, 8'hA5, 1'b0);
    @(negedge clk);
    t_read(19'h7FFFF, 8'hA5);
    @(negedge clk);
    t_busy_ignored();
    @(negedge clk);
    t_back_to_back();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule